// File: doc/BRIEF.md
# Flash Thermometer to Binary Encoder (Gray Intermediate)

This block turns the comparator word of a four-bit flash converter into a binary sample. The fifteen comparators are ordered by trip level, so a clean input is a thermometer code: a solid run of ones starting at the lowest comparator. A synchronous capture register samples that word whenever the enable strobe is high. A single combinational path then forms a four-bit reflected (Gray) code and converts it to binary. A second register holds the binary result and raises a valid flag.

Each Gray bit is computed from its own small, fixed set of comparator taps, and no two Gray bits share a tap. There is no one-hot or priority stage in between. A bubble (a stray zero inside the run of ones) can therefore disturb at most one Gray bit. The Gray-to-binary chain then spreads that single disturbance in a known way: a bubble on an odd comparator moves the result by at most one LSB. Results come out two clock edges after the strobe, one per cycle, with no stall.

Top module: `therm_bin_encoder`

## Requirements
- R1: A synchronous active-high `rst` clears `bin_out` to 0 and `bin_vld` to 0 at the clock edge that samples it. It also drops any sample already captured, so `bin_vld` stays low on the cycle after reset is released.
- R2: `bin_vld` is high exactly when `in_en` was high at the rising edge two edges earlier, with no reset in between. Reset sampled on either of those two edges forces it low.
- R3: Comparator i (i = 1..15) is bit i-1 of `therm_in`, so bit 0 has the lowest trip level. A legal thermometer code, meaning the lowest n bits set and the rest clear (n = 0..15), produces `bin_out` = n. All zeros gives 0 and all ones gives 15.
- R4: Gray bit b (b = 0 is the LSB) looks only at the comparators whose index is an odd multiple of 2^b. It is set when, for some m ≥ 0, comparator (4m+1)·2^b is high and comparator (4m+3)·2^b is low. A partner index above 15 counts as low. As a result, the Gray MSB equals comparator 8.
- R5: Binary is produced from the MSB down. The binary MSB equals the Gray MSB, and every lower binary bit is its Gray bit XOR the binary bit just above it. A word with only comparator 8 high gives 15, only comparator 4 gives 7, only comparator 2 gives 3, and only comparator 1 gives 1.
- R6: Take a single-bubble word: comparators 1..n high except one comparator p with 2 ≤ p ≤ n-1. If p is odd, `bin_out` is n or n XOR 1, which is within one LSB of n.
- R7: For a single-bubble word whose bubble p is even, `bin_out` equals the value that R4 followed by R5 give for that word. Only the Gray bit whose tap set holds p can differ from the clean code n.
- R8: On an edge where no valid sample is captured, `bin_out` keeps its previous value, whatever `therm_in` carries.
- R9: Holding `in_en` high on consecutive edges gives one result per cycle, each result matching its own input word, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Capture strobe for `therm_in` |
| therm_in | input | 15 | Comparator outputs; bit 0 has the lowest trip level |
| bin_out | output | 4 | Registered binary sample |
| bin_vld | output | 1 | High for the cycle in which `bin_out` holds a new sample |

## Verification
The bench builds the block at its default resolution of four bits, which gives fifteen comparator taps. At that size the input space is small enough to cover completely where it matters. The bench runs every one of the sixteen legal thermometer codes, both as isolated conversions and as one unbroken stream. It also runs all ninety-one single-bubble placements, which makes it possible to separate bubbles on odd comparators from bubbles on even ones. On top of that, single-tap and arbitrary words check the Gray tap rule and the binary chain against a reference model written from the requirements.

// File: rtl/therm_enc_pkg.sv
`timescale 1ns/1ps
package therm_enc_pkg;

    // Resolution of the converter and the comparator count it implies
    localparam int unsigned ENC_RES  = 4;
    localparam int unsigned ENC_TAPS = (1 << ENC_RES) - 1;

    typedef logic [ENC_TAPS-1:0] therm_t;
    typedef logic [ENC_RES-1:0]  code_t;

    // Capture stage: comparator word plus its strobe
    typedef struct packed {
        logic   live;
        therm_t taps;
    } cap_t;

    // Result stage: binary code plus its valid flag
    typedef struct packed {
        logic  live;
        code_t code;
    } res_t;

endpackage

// File: rtl/therm_gray_taps.sv
`timescale 1ns/1ps
module therm_gray_taps #(
    parameter  int unsigned RES  = therm_enc_pkg::ENC_RES,
    localparam int unsigned TAPS = (1 << RES) - 1
) (
    input  logic [TAPS-1:0] cmp,
    output logic [RES-1:0]  gray
);

    for (genvar b = 0; b < RES; b++) begin : g_bit
        localparam int unsigned STEP  = 1 << b;
        localparam int unsigned NPAIR = (TAPS / STEP + 3) / 4;
        logic [NPAIR-1:0] hit;

        for (genvar m = 0; m < NPAIR; m++) begin : g_pair
            localparam int unsigned LO = (4 * m + 1) * STEP;
            localparam int unsigned HI = (4 * m + 3) * STEP;
            if (HI <= TAPS) begin : g_full
                assign hit[m] = cmp[LO-1] & ~cmp[HI-1];
            end else begin : g_open
                assign hit[m] = cmp[LO-1];
            end
        end

        assign gray[b] = |hit;
    end

    // A legal run of ones must land on the reflected code of its length
    always_comb begin : refl_chk_blk
        int unsigned     ones;
        logic [TAPS-1:0] nxt;
        ones = 0;
        for (int i = 0; i < TAPS; i++) ones = ones + 32'(cmp[i]);
        nxt = cmp + TAPS'(1);
        if ((cmp & nxt) == '0) begin
            // R3
            gray_refl_chk: assert (RES'(ones ^ (ones >> 1)) == gray);
        end
    end

endmodule

// File: rtl/gray_to_bin.sv
`timescale 1ns/1ps
module gray_to_bin #(
    parameter int unsigned RES = therm_enc_pkg::ENC_RES
) (
    input  logic [RES-1:0] gray,
    output logic [RES-1:0] bin
);

    for (genvar b = RES - 1; b >= 0; b--) begin : g_chain
        if (b == RES - 1) begin : g_top
            assign bin[b] = gray[b];
        end else begin : g_low
            assign bin[b] = gray[b] ^ bin[b+1];
        end
    end

    // Re-encoding the binary result must give back the Gray input
    always_comb begin
        // R5
        gray_inv_chk: assert ((bin ^ (bin >> 1)) == gray);
    end

endmodule

// File: rtl/therm_bin_encoder.sv
`timescale 1ns/1ps
module therm_bin_encoder
    import therm_enc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_en,
    input  logic [ENC_TAPS-1:0] therm_in,
    output logic [ENC_RES-1:0]  bin_out,
    output logic                bin_vld
);

    cap_t  cap_q;
    res_t  res_q;
    code_t gray_w;
    code_t bin_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.live <= in_en;
            cap_q.taps <= therm_in;
        end
    end

    therm_gray_taps #(.RES(ENC_RES)) u_taps (
        .cmp  (cap_q.taps),
        .gray (gray_w)
    );

    gray_to_bin #(.RES(ENC_RES)) u_g2b (
        .gray (gray_w),
        .bin  (bin_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.live <= cap_q.live;
            if (cap_q.live) res_q.code <= bin_w;
        end
    end

    assign bin_out = res_q.code;
    assign bin_vld = res_q.live;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bin_out == '0 && !bin_vld));

    // R2
    vld_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (bin_vld == $past(in_en, 2)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bin_vld && !$past(rst)) |-> $stable(bin_out));

endmodule

// File: tb/tb_therm_bin_encoder.sv
`timescale 1ns/1ps
module tb_therm_bin_encoder;
    import therm_enc_pkg::*;

    logic   clk;
    logic   rst;
    logic   in_en;
    therm_t therm_in;
    code_t  bin_out;
    logic   bin_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    therm_bin_encoder dut (
        .clk      (clk),
        .rst      (rst),
        .in_en    (in_en),
        .therm_in (therm_in),
        .bin_out  (bin_out),
        .bin_vld  (bin_vld)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // Reference Gray formation from the tap rule (R4)
    function automatic int model_gray(therm_t t);
        int g = 0;
        for (int b = 0; b < ENC_RES; b++) begin
            int step = 1 << b;
            bit any = 0;
            for (int lo = step; lo <= ENC_TAPS; lo += 4 * step) begin
                int hi = lo + 2 * step;
                if (hi <= ENC_TAPS) begin
                    if (t[lo-1] && !t[hi-1]) any = 1;
                end else begin
                    if (t[lo-1]) any = 1;
                end
            end
            if (any) g |= step;
        end
        return g;
    endfunction

    // Reference binary chain (R5)
    function automatic int model_bin(int g);
        int r = 0;
        int up = 0;
        for (int b = ENC_RES - 1; b >= 0; b--) begin
            up = ((g >> b) & 1) ^ up;
            r |= up << b;
        end
        return r;
    endfunction

    function automatic therm_t run_of(int n);
        return therm_t'((1 << n) - 1);
    endfunction

    // One isolated conversion; result sampled two edges after capture
    task automatic convert(input therm_t t, output int got, output int vld);
        @(negedge clk);
        in_en    = 1'b1;
        therm_in = t;
        @(negedge clk);
        in_en    = 1'b0;
        therm_in = ~t;
        @(negedge clk);
        got = int'(bin_out);
        vld = int'(bin_vld);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_en = 1'b0; therm_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset bin_out", int'(bin_out), 0);
        chk("R1 reset bin_vld", int'(bin_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release bin_vld", int'(bin_vld), 0);
    endtask

    task automatic t_legal_codes();
        int got, vld;
        for (int n = 0; n <= ENC_TAPS; n++) begin
            convert(run_of(n), got, vld);
            chk($sformatf("R3 run of %0d", n), got, n);
            chk("R2 valid after strobe", vld, 1);
        end
        @(negedge clk);
        chk("R2 valid drops", int'(bin_vld), 0);
    endtask

    task automatic t_single_taps();
        int got, vld;
        convert(therm_t'(1 << 7), got, vld); chk("R5 only comparator 8", got, 15);
        convert(therm_t'(1 << 3), got, vld); chk("R5 only comparator 4", got, 7);
        convert(therm_t'(1 << 1), got, vld); chk("R5 only comparator 2", got, 3);
        convert(therm_t'(1 << 0), got, vld); chk("R5 only comparator 1", got, 1);
    endtask

    task automatic t_arbitrary();
        int got, vld;
        for (int k = 0; k < 40; k++) begin
            therm_t t = therm_t'($urandom);
            convert(t, got, vld);
            chk($sformatf("R4 word %0h", t), got, model_bin(model_gray(t)));
        end
    endtask

    task automatic t_bubbles();
        int got, vld;
        for (int n = 3; n <= ENC_TAPS; n++) begin
            for (int p = 2; p < n; p++) begin
                therm_t t = run_of(n);
                t[p-1] = 1'b0;
                convert(t, got, vld);
                if (p % 2 == 1) begin
                    chk($sformatf("R6 n=%0d p=%0d near n", n, p),
                        int'(got == n || got == (n ^ 1)), 1);
                end else begin
                    chk($sformatf("R7 n=%0d p=%0d", n, p), got,
                        model_bin(model_gray(t)));
                end
            end
        end
    endtask

    task automatic t_hold();
        int got, vld;
        convert(run_of(9), got, vld);
        chk("R8 seed value", got, 9);
        for (int k = 0; k < 4; k++) begin
            in_en    = 1'b0;
            therm_in = run_of(2 + 3 * k);
            @(negedge clk);
            chk("R8 held value", int'(bin_out), 9);
            chk("R8 no valid", int'(bin_vld), 0);
        end
    endtask

    task automatic t_stream();
        for (int k = 0; k <= ENC_TAPS + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk($sformatf("R9 stream code %0d", k - 2), int'(bin_out), k - 2);
                chk("R9 stream valid", int'(bin_vld), 1);
            end
            if (k <= ENC_TAPS) begin
                in_en    = 1'b1;
                therm_in = run_of(k);
            end else begin
                in_en    = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 stream end valid", int'(bin_vld), 0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        in_en = 1'b1; therm_in = run_of(7);
        @(negedge clk);
        rst = 1'b1; in_en = 1'b0;
        @(negedge clk);
        chk("R1 mid reset bin_out", int'(bin_out), 0);
        chk("R1 mid reset bin_vld", int'(bin_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dropped capture", int'(bin_vld), 0);
        chk("R1 dropped capture value", int'(bin_out), 0);
    endtask

    initial begin
        t_reset();
        t_legal_codes();
        t_single_taps();
        t_arbitrary();
        t_bubbles();
        t_hold();
        t_stream();
        t_mid_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule